// File: doc/BRIEF.md
# Self-Timing Asynchronous Serial Transceiver

This block is a serial receiver and transmitter that has no fixed bit rate. At the start of every command, it times the low start bit of the first octet against the system clock. It holds that count as the bit period, decodes the octets that follow with it, and sends the reply at the same rate. The first octet of a command must have its least significant bit set. The start bit then ends at the first rising edge of the line, so the low run that is timed is exactly one bit long.

Received octets appear as a one-cycle valid pulse that carries the data and a framing-error flag. Octets to send are offered on a ready/valid pair. The transmitter accepts an octet only while a bit period is held. The held period is released once the line, the receiver and the transmitter have all stayed idle for more than `IDLE_BITS` bit times. The next falling edge then starts a new measurement. Parity, flow control, extra stop bits and any meaning of the octets are left to the surrounding logic.

Top module: `autobaud_uart`

## Requirements
- R1: A low run that starts at an idle falling edge and lasts L clock cycles is accepted as the bit period when L lies between F - F/8 and S + S/8, where F = CLK_HZ/76800 and S = CLK_HZ/1200. The octet that begins with it is then received with period L.
- R2: A first low run shorter or longer than that window is rejected. No octet is delivered, `tx_ready_o` stays 0, and the receiver waits for the next falling edge.
- R3: Data bits are taken least significant bit first, each near the middle of its bit period. Each octet is presented on `rx_data_o` with `rx_valid_o` high for exactly one cycle.
- R4: `rx_ferr_o` is 1 together with the valid pulse when the stop bit is sampled low, and 0 when it is sampled high.
- R5: While a period is held, later octets of the command are decoded with that period. This includes octets whose bit 0 is 0.
- R6: A transmitted octet is framed as a low start bit, then 8 data bits least significant bit first, then a high stop bit. Each bit lasts exactly the held period in clock cycles. Between octets `txd_o` idles high.
- R7: `tx_ready_o` is 1 only while a period is held and the transmitter is idle. An octet is taken in the cycle in which `tx_valid_i` and `tx_ready_o` are both high, and `tx_ready_o` is 0 while that octet is being sent.
- R8: After the line has stayed high, with the receiver and the transmitter both idle, for more than IDLE_BITS held periods, the period is released and `tx_ready_o` drops to 0. The next command is then measured afresh, at its own rate.
- R9: After reset, `txd_o` is 1, `tx_ready_o` is 0 and no valid pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial input line |
| txd_o | output | 1 | Serial output line, idles high |
| rx_valid_o | output | 1 | One-cycle pulse marking a received octet |
| rx_data_o | output | 8 | Received octet |
| rx_ferr_o | output | 1 | Stop bit was low for the presented octet |
| tx_valid_i | input | 1 | An octet to send is offered |
| tx_data_i | input | 8 | Octet to send |
| tx_ready_o | output | 1 | Transmitter can accept an octet at the held rate |

## Verification
The bench builds the block with CLK_HZ = 1_228_800 and IDLE_BITS = 4. With that clock, 76800 bit/s is 16 clocks per bit and 1200 bit/s is 1024 clocks per bit. Both edges of the accepted window (14 and 1152 clocks) and both rejection points just outside it (13 and 1153) therefore fall within short runs. The small IDLE_BITS lets each vector release the held period and re-measure at a different rate, so every rate switch and the timeout are exercised as well as plain reception.

// File: rtl/uab_pkg.sv
// Package uab_pkg
// Shared state encodings for the self-timing serial transceiver.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package uab_pkg;

    // Rate meter: waiting for an edge, timing a start bit, or holding a period.
    typedef enum logic [1:0] {
        MT_HUNT    = 2'd0,
        MT_MEASURE = 2'd1,
        MT_LOCKED  = 2'd2
    } meter_st_t;

    // Receiver: idle, confirming a start bit, shifting data, checking stop.
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_st_t;

endpackage

// File: rtl/uab_rate_meter.sv
// Module uab_rate_meter
// Times the low start bit of a command's first octet and holds the result
// as the bit period. The period is released after an idle interval that is
// longer than IDLE_BITS periods.
// Assumes: the line input is already synchronised; the first octet of a
// command has bit 0 set, so its start bit ends at the first rising edge.
module uab_rate_meter
    import uab_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int LO_CNT    = 14,
    parameter int HI_CNT    = 1152,
    parameter int IDLE_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             fall,
    input  logic             rx_busy,
    input  logic             tx_busy,
    output logic             locked_o,
    output logic [CNT_W-1:0] period_o,
    output logic             launch_o
);

    localparam int IB_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] LO_C   = CNT_W'(LO_CNT);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(HI_CNT);
    localparam logic [IB_W-1:0]  IB_END = IB_W'(IDLE_BITS);

    meter_st_t        state;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] idle_cyc;
    logic [IB_W-1:0]  idle_bits;
    logic             run_ok;
    logic             all_idle;

    // Accepts a timed run only inside the supported window.
    always_comb begin
        run_ok   = (run_cnt >= LO_C) && (run_cnt <= HI_C);
        all_idle = line && !rx_busy && !tx_busy;
    end

    // Sequences hunt, measurement, hold and idle release of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MT_HUNT;
            run_cnt   <= '0;
            period_o  <= LO_C;
            idle_cyc  <= '0;
            idle_bits <= '0;
            launch_o  <= 1'b0;
        end else begin
            launch_o <= 1'b0;
            case (state)
                MT_HUNT: begin
                    if (fall) begin
                        state   <= MT_MEASURE;
                        run_cnt <= CNT_W'(1);
                    end
                end
                MT_MEASURE: begin
                    if (line) begin
                        if (run_ok) begin
                            state     <= MT_LOCKED;
                            period_o  <= run_cnt;
                            launch_o  <= 1'b1;
                            idle_cyc  <= '0;
                            idle_bits <= '0;
                        end else begin
                            state <= MT_HUNT;
                        end
                    end else if (run_cnt <= HI_C) begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
                MT_LOCKED: begin
                    if (!all_idle) begin
                        idle_cyc  <= '0;
                        idle_bits <= '0;
                    end else if (idle_cyc == period_o - 1'b1) begin
                        idle_cyc <= '0;
                        if (idle_bits == IB_END) begin
                            state <= MT_HUNT;
                        end else begin
                            idle_bits <= idle_bits + 1'b1;
                        end
                    end else begin
                        idle_cyc <= idle_cyc + 1'b1;
                    end
                end
                default: state <= MT_HUNT;
            endcase
        end
    end

    assign locked_o = (state == MT_LOCKED);

    AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (period_o >= LO_C && period_o <= HI_C)); // R1

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o)) |-> $stable(period_o)); // R5

endmodule

// File: rtl/uab_rx.sv
// Module uab_rx
// Receives 8N1 octets, least significant bit first. Each bit is sampled at
// the middle of the held period, and the stop bit is checked.
// Assumes: synchronised line; launch marks the start of bit 0 of an octet
// whose start bit the rate meter has already consumed.
module uab_rx
    import uab_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic             fall,
    input  logic             locked,
    input  logic             launch,
    input  logic [CNT_W-1:0] period,
    output logic             busy_o,
    output logic             valid_o,
    output logic [7:0]       data_o,
    output logic             ferr_o
);

    rx_st_t           state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] preload;
    logic             bit_end;

    // Derives the half period and the launch offset into bit 0.
    always_comb begin
        half    = period >> 1;
        preload = period - half + 1'b1;
        bit_end = (cnt == period - 1'b1);
    end

    // Walks one octet from start confirmation to stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            valid_o <= 1'b0;
            data_o  <= '0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (launch) begin
                        state   <= RX_DATA;
                        cnt     <= preload;
                        bit_idx <= '0;
                    end else if (locked && fall) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == half - 1'b1) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[7:1]};
                        if (bit_idx == 3'd7) begin
                            state <= RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        cnt     <= '0;
                        valid_o <= 1'b1;
                        data_o  <= shreg;
                        ferr_o  <= !line;
                        state   <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign busy_o = (state != RX_IDLE);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R3

endmodule

// File: rtl/uab_tx.sv
// Module uab_tx
// Sends 8N1 octets at the held bit period: a low start bit, 8 data bits
// least significant bit first, then a high stop bit.
// Assumes: the period does not change while the transmitter is busy; the
// rate meter keeps it held because a busy transmitter resets its idle timer.
module uab_tx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic [CNT_W-1:0] period,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             busy_o,
    output logic             txd_o
);

    localparam int FRAME_BITS = 10;

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      cnt;
    logic [3:0]            bit_idx;

    // Loads a frame on handshake and shifts one bit per held period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            shreg   <= '1;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (!busy_o) begin
            if (tx_valid && tx_ready) begin
                busy_o  <= 1'b1;
                shreg   <= {1'b1, tx_data, 1'b0};
                cnt     <= '0;
                bit_idx <= '0;
            end
        end else if (cnt == period - 1'b1) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
            if (bit_idx == 4'(FRAME_BITS - 1)) begin
                busy_o <= 1'b0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tx_ready = locked && !busy_o;
    assign txd_o    = busy_o ? shreg[0] : 1'b1;

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd_o); // R6

endmodule

// File: rtl/autobaud_uart.sv
// Module autobaud_uart
// Top of the self-timing serial transceiver. It synchronises the input line,
// measures the bit period per command, and connects the receiver and the
// transmitter to the held period.
// Assumes: a single clock of CLK_HZ; SYNC_STAGES >= 2; CLK_HZ >= 8 * 76800,
// so the shortest accepted period stays at several clocks.
module autobaud_uart #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int IDLE_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_ferr_o,
    input  logic       tx_valid_i,
    input  logic [7:0] tx_data_i,
    output logic       tx_ready_o
);

    localparam int FAST_CNT = CLK_HZ / 76800;
    localparam int SLOW_CNT = CLK_HZ / 1200;
    localparam int LO_CNT   = FAST_CNT - FAST_CNT / 8;
    localparam int HI_CNT   = SLOW_CNT + SLOW_CNT / 8;
    localparam int CNT_W    = $clog2(HI_CNT + 2);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line;
    logic                   line_q;
    logic                   fall;
    logic                   locked;
    logic [CNT_W-1:0]       period;
    logic                   launch;
    logic                   rx_busy;
    logic                   tx_busy;

    // Brings the asynchronous line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
            line_q <= line;
        end
    end

    assign line = sync_q[SYNC_STAGES-1];
    assign fall = line_q && !line;

    uab_rate_meter #(
        .CNT_W    (CNT_W),
        .LO_CNT   (LO_CNT),
        .HI_CNT   (HI_CNT),
        .IDLE_BITS(IDLE_BITS)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line),
        .fall    (fall),
        .rx_busy (rx_busy),
        .tx_busy (tx_busy),
        .locked_o(locked),
        .period_o(period),
        .launch_o(launch)
    );

    uab_rx #(
        .CNT_W(CNT_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (line),
        .fall   (fall),
        .locked (locked),
        .launch (launch),
        .period (period),
        .busy_o (rx_busy),
        .valid_o(rx_valid_o),
        .data_o (rx_data_o),
        .ferr_o (rx_ferr_o)
    );

    uab_tx #(
        .CNT_W(CNT_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (locked),
        .period  (period),
        .tx_valid(tx_valid_i),
        .tx_data (tx_data_i),
        .tx_ready(tx_ready_o),
        .busy_o  (tx_busy),
        .txd_o   (txd_o)
    );

    AST_READY_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> txd_o); // R7

    AST_NO_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !$past(locked)) |-> !rx_valid_o); // R2

endmodule

// File: tb/sim_autobaud_uart.sv
`timescale 1ns/1ps
module sim_autobaud_uart;

    localparam int CLK_HZ    = 1_228_800;
    localparam int IDLE_BITS = 4;
    localparam int NVEC      = 5;
    // {period in clocks, first octet (bit 0 set), second octet}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd16,   8'h23, 8'h5A},
        {16'd1152, 8'h21, 8'h3C},
        {16'd100,  8'h2F, 8'h00},
        {16'd37,   8'h23, 8'hFF},
        {16'd14,   8'h21, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       txd_o;
    logic       rx_valid_o;
    logic [7:0] rx_data_o;
    logic       rx_ferr_o;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready_o;

    int checks = 0;
    int errors = 0;
    int got_n  = 0;
    logic [7:0] got_data [64];
    logic       got_ferr [64];

    always #2.5 clk = ~clk;

    autobaud_uart #(.CLK_HZ(CLK_HZ), .IDLE_BITS(IDLE_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd_o),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_ferr_o(rx_ferr_o),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready_o)
    );

    // Records every received octet, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid_o && got_n < 64) begin
            got_data[got_n] = rx_data_o;
            got_ferr[got_n] = rx_ferr_o;
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input int p, input logic [7:0] b, input logic stop);
        rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = b[k];
            repeat (p) @(negedge clk);
        end
        rxd = stop;
        repeat (p) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic do_tx(input int p, input logic [7:0] b);
        int lo;
        int waitc;
        logic [7:0] seen;
        logic stopb;
        waitc = 0;
        while (!tx_ready_o && waitc < 100) begin
            @(negedge clk);
            waitc++;
        end
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready_o == 1'b0, "R7 ready low while sending", int'(tx_ready_o), 0);
        waitc = 0;
        while (txd_o && waitc < 100) begin
            @(negedge clk);
            waitc++;
        end
        lo = 0;
        while (!txd_o && lo < 5000) begin
            @(negedge clk);
            lo++;
        end
        chk(lo == p, "R6 start bit length equals measured period", lo, p);
        seen = 8'h00;
        repeat (p / 2 - 1) @(negedge clk);
        seen[0] = txd_o;
        for (int k = 1; k < 8; k++) begin
            repeat (p) @(negedge clk);
            seen[k] = txd_o;
        end
        repeat (p) @(negedge clk);
        stopb = txd_o;
        chk(seen == b, "R6 transmitted octet LSB first", int'(seen), int'(b));
        chk(stopb == 1'b1, "R6 stop bit high", int'(stopb), 1);
        repeat (p) @(negedge clk);
        chk(tx_ready_o == 1'b1 && txd_o == 1'b1, "R7 ready again with line idle high",
            int'(tx_ready_o), 1);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p;
        int base;
        logic [7:0] b0;
        logic [7:0] b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(txd_o == 1'b1, "R9 txd idle high", int'(txd_o), 1);
        chk(tx_ready_o == 1'b0, "R9 ready low before any rate", int'(tx_ready_o), 0);
        chk(got_n == 0, "R9 no octet after reset", got_n, 0);

        // R2: start bit one clock too short
        rxd = 1'b0;
        repeat (13) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk(got_n == 0 && tx_ready_o == 1'b0, "R2 short run rejected", got_n, 0);
        // R2: start bit one clock too long
        rxd = 1'b0;
        repeat (1153) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        chk(got_n == 0 && tx_ready_o == 1'b0, "R2 long run rejected", got_n, 0);

        // Vector walk: R1 R3 R5 R6 R7 R8 at several rates
        for (int i = 0; i < NVEC; i++) begin
            p  = int'(VEC[i][31:16]);
            b0 = VEC[i][15:8];
            b1 = VEC[i][7:0];
            base = got_n;
            send_byte(p, b0, 1'b1);
            send_byte(p, b1, 1'b1);
            repeat (4) @(negedge clk);
            chk(got_n == base + 2, "R1 two octets at measured rate", got_n - base, 2);
            if (got_n == base + 2) begin
                chk(got_data[base] == b0, "R3 first octet LSB first",
                    int'(got_data[base]), int'(b0));
                chk(got_data[base + 1] == b1, "R5 later octet with held period",
                    int'(got_data[base + 1]), int'(b1));
                chk(!got_ferr[base] && !got_ferr[base + 1], "R4 no framing error",
                    int'(got_ferr[base + 1]), 0);
            end
            chk(tx_ready_o == 1'b1, "R7 ready while period held", int'(tx_ready_o), 1);
            do_tx(p, b0);
            repeat ((IDLE_BITS + 2) * p + 10) @(negedge clk);
            chk(tx_ready_o == 1'b0, "R8 period released after idle", int'(tx_ready_o), 0);
        end

        // R4: framing error on the second octet
        base = got_n;
        send_byte(20, 8'h21, 1'b1);
        send_byte(20, 8'h96, 1'b0);
        repeat (30) @(negedge clk);
        chk(got_n == base + 2, "R4 both octets delivered", got_n - base, 2);
        if (got_n == base + 2) begin
            chk(got_ferr[base] == 1'b0, "R4 good stop flag clear", int'(got_ferr[base]), 0);
            chk(got_ferr[base + 1] == 1'b1, "R4 low stop flagged",
                int'(got_ferr[base + 1]), 1);
            chk(got_data[base + 1] == 8'h96, "R4 data kept on framing error",
                int'(got_data[base + 1]), 'h96);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule